// File: doc/BRIEF.md
# I2C Block-Transfer Control Register Slave

This block is a slave-only I2C endpoint that holds a small bank of 8-bit control registers. A fast system clock samples the bus lines. The block pulls SDA low through an active-low open-drain enable. The host never addresses an individual register. A write transaction carries two header bytes (a command code and a byte count) that the slave acknowledges and discards. The data bytes that follow fill the registers from the lowest index upward. A read transaction returns a byte count and then every register in ascending order.

The register contents appear on a flat parallel bus, byte `i` at bits `[8i+7:8i]`. Downstream control logic, such as output-enable gating, can use this bus directly. The 7-bit device address is a parameter. With the default address, the write address byte is 0xD4 and the read address byte is 0xD5.

Top module: `i2cb_slave`

## Requirements
- R1: On synchronous reset, register `i` loads 0xA0+i, and `sda_oe` is 0 (SDA released).
- R2: The slave acknowledges the address byte 0xD4 (write) and the address byte 0xD5 (read).
- R3: In a write, the slave acknowledges the two bytes after the address and discards their values. Data bytes then load registers 0, 1, … 6 in order, each received MSB first and each acknowledged. Register `i` appears on `ctrl_o[8i+7:8i]`.
- R4: A stop after any complete data byte ends the write. Registers already written keep their new values, and the other registers keep their earlier values.
- R5: A read first returns the byte count 7 and then registers 0 to 6 in ascending order, each MSB first. The host acknowledges each byte.
- R6: A NACK from the host ends a read. SDA stays released (reads as 0xFF) until the next start.
- R7: Write data bytes after register 6 are not acknowledged and change no register.
- R8: An address byte other than 0xD4 or 0xD5 is not acknowledged. The slave then ignores the bus until the next start, and no register changes.
- R9: A repeated start in the middle of a transaction restarts address reception. Registers written before the repeated start keep their values.
- R10: `sda_oe` changes only while SCL is low. A stop (SDA rising while SCL is high) returns the slave to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| ctrl_o | output | NUM_REGS*8 | Register contents, byte i at [8i+7:8i] |

## Verification
The assertions assume a well-behaved host. It changes SDA only while SCL is low, except to signal a start or a stop. It holds each SCL phase for many system clocks, so the synchronizer delay always settles inside the phase. It never issues a start or a stop while the slave is pulling SDA low. The bench host model holds each quarter bit for eight system clocks and moves SDA one quarter after SCL falls. It releases SDA before every acknowledge slot and before every byte the slave transmits. Random write lengths from one to nine data bytes fall on both sides of the register-count boundary.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } i2cb_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } i2cb_evt_t;

    localparam int HDR_BYTES = 2;

    function automatic logic [7:0] reg_default(input int idx);
        return 8'hA0 + 8'(idx);
    endfunction

endpackage

// File: rtl/i2cb_sync.sv
module i2cb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~prev;
    assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/i2cb_regbank.sv
module i2cb_regbank
    import i2cb_pkg::*;
#(
    parameter int NUM_REGS = 7,
    parameter int IDX_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    output logic [NUM_REGS*8-1:0] regs_o
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_o[8*i +: 8] <= reg_default(i);
            else if (wr_en && wr_idx == IDX_W'(i))
                regs_o[8*i +: 8] <= wr_data;
        end
    end

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_idx) < NUM_REGS)); // R7
endmodule

// File: rtl/i2cb_slave.sv
module i2cb_slave
    import i2cb_pkg::*;
#(
    parameter int         NUM_REGS    = 7,
    parameter logic [6:0] DEV_ADDR    = 7'h6A,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] ctrl_o
);
    localparam int IDX_W = $clog2(NUM_REGS + HDR_BYTES + 2);
    localparam logic [IDX_W-1:0] HDR_L  = IDX_W'(HDR_BYTES);
    localparam logic [IDX_W-1:0] WR_END = IDX_W'(HDR_BYTES + NUM_REGS);
    localparam logic [IDX_W-1:0] TX_END = IDX_W'(NUM_REGS);

    logic scl_lvl, scl_r, scl_f;
    logic sda_lvl, sda_r, sda_f;
    i2cb_evt_t ev;

    i2cb_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst(rst), .din(scl_i), .lvl(scl_lvl), .rise(scl_r), .fall(scl_f));
    i2cb_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst(rst), .din(sda_i), .lvl(sda_lvl), .rise(sda_r), .fall(sda_f));

    always_comb begin
        ev.start    = scl_lvl & sda_f;
        ev.stop     = scl_lvl & sda_r;
        ev.scl_rise = scl_r;
        ev.scl_fall = scl_f;
    end

    i2cb_state_e      state;
    logic [3:0]       bitcnt;
    logic [7:0]       shreg;
    logic [IDX_W-1:0] idx;
    logic             is_addr;
    logic             rd_mode;
    logic             host_ack;

    // byte decision after the 8th bit of a received byte
    logic             byte_done;
    logic             do_ack;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rix;
    logic [7:0]       tx_byte;

    assign byte_done = (state == ST_RX) && ev.scl_fall && (bitcnt == 4'd8);
    assign do_ack    = is_addr ? (shreg[7:1] == DEV_ADDR) : (idx < WR_END);
    assign wr_idx    = idx - HDR_L;
    assign wr_en     = byte_done && !is_addr && !rd_mode && (idx >= HDR_L) && (idx < WR_END);
    assign rix       = idx - 1'b1;

    always_comb begin
        if (idx == '0)
            tx_byte = 8'(NUM_REGS);
        else if (idx <= TX_END)
            tx_byte = ctrl_o[8*rix +: 8];
        else
            tx_byte = 8'hFF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            sda_oe   <= 1'b0;
            bitcnt   <= '0;
            shreg    <= '0;
            idx      <= '0;
            is_addr  <= 1'b0;
            rd_mode  <= 1'b0;
            host_ack <= 1'b0;
        end else if (ev.start) begin
            state   <= ST_RX;
            sda_oe  <= 1'b0;
            bitcnt  <= '0;
            idx     <= '0;
            is_addr <= 1'b1;
            rd_mode <= 1'b0;
        end else if (ev.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_RX: begin
                    if (ev.scl_rise && bitcnt < 4'd8) begin
                        shreg  <= {shreg[6:0], sda_lvl};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        bitcnt  <= '0;
                        is_addr <= 1'b0;
                        if (is_addr) begin
                            rd_mode <= shreg[0];
                            state   <= do_ack ? ST_RX_ACK : ST_IDLE;
                        end else begin
                            state <= ST_RX_ACK;
                            if (idx != '1) idx <= idx + 1'b1;
                        end
                        sda_oe <= do_ack;
                    end
                end
                ST_RX_ACK: begin
                    if (ev.scl_fall) begin
                        bitcnt <= '0;
                        if (rd_mode) begin
                            state  <= ST_TX;
                            shreg  <= tx_byte;
                            sda_oe <= ~tx_byte[7];
                            idx    <= idx + 1'b1;
                        end else begin
                            state  <= ST_RX;
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            state  <= ST_TX_ACK;
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                        end else begin
                            shreg  <= {shreg[6:0], 1'b1};
                            sda_oe <= ~shreg[6];
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (ev.scl_rise) host_ack <= ~sda_lvl;
                    if (ev.scl_fall) begin
                        if (host_ack) begin
                            state  <= ST_TX;
                            shreg  <= tx_byte;
                            sda_oe <= ~tx_byte[7];
                            if (idx != '1) idx <= idx + 1'b1;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    state  <= ST_IDLE;
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

    i2cb_regbank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(shreg), .regs_o(ctrl_o));

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !scl_lvl); // R10
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (state == ST_IDLE && !sda_oe)); // R10
    AST_START_RESTART: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (state == ST_RX && is_addr && !sda_oe)); // R9
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe); // R6
    AST_NACK_ENDS_READ: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TX_ACK && ev.scl_fall && !host_ack && !ev.start && !ev.stop)
        |=> (state == ST_IDLE)); // R6
    AST_BAD_ADDR_IDLE: assert property (@(posedge clk) disable iff (rst)
        (byte_done && is_addr && shreg[7:1] != DEV_ADDR && !ev.start && !ev.stop)
        |=> (state == ST_IDLE && !sda_oe)); // R8
endmodule

// File: tb/i2cb_slave_tb.sv
module i2cb_slave_tb_top;
    localparam int NREG = 7;
    localparam int Q    = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hscl = 1'b1;
    logic hsda = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [NREG*8-1:0] ctrl_o;

    int errors = 0;
    int checks = 0;
    int oe_viol = 0;
    logic [7:0] model [NREG];
    logic [7:0] wbuf [10];

    always #10 clk = ~clk;

    assign sda_line = hsda & ~sda_oe;

    i2cb_slave dut_i (
        .clk(clk), .rst(rst), .scl_i(hscl), .sda_i(sda_line),
        .sda_oe(sda_oe), .ctrl_o(ctrl_o));

    // R10: open-drain enable must only move while the bus clock is low
    logic oe_prev = 1'b0;
    always @(posedge clk) begin
        if (!rst && sda_oe != oe_prev && hscl) oe_viol++;
        oe_prev <= sda_oe;
    end

    function automatic logic [7:0] dflt(input int i);
        return 8'hA0 + 8'(i);
    endfunction

    function automatic logic [NREG*8-1:0] pack_model();
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[8*i +: 8] = model[i];
        return v;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        hsda = 1'b1; hq();
        hscl = 1'b1; hq();
        hsda = 1'b0; hq();
        hscl = 1'b0; hq();
    endtask

    task automatic i2c_stop();
        hsda = 1'b0; hq();
        hscl = 1'b1; hq();
        hsda = 1'b1; hq();
    endtask

    task automatic send(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            hsda = b[i]; hq();
            hscl = 1'b1; hq(); hq();
            hscl = 1'b0; hq();
        end
        hsda = 1'b1; hq();
        hscl = 1'b1; hq();
        ack = ~sda_line; hq();
        hscl = 1'b0; hq();
    endtask

    task automatic recv(input logic ack, output logic [7:0] b);
        hsda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hq();
            hscl = 1'b1; hq();
            b[i] = sda_line; hq();
            hscl = 1'b0; hq();
        end
        hsda = ~ack; hq();
        hscl = 1'b1; hq(); hq();
        hscl = 1'b0; hq();
        hsda = 1'b1;
    endtask

    task automatic wr_block(input int n, input string tag);
        logic a;
        i2c_start();
        send(8'hD4, a);                chk({tag, "/R2 wr addr ack"}, 64'(a), 64'd1);
        send(8'($urandom), a);         chk({tag, "/R3 cmd ack"}, 64'(a), 64'd1);
        send(8'($urandom), a);         chk({tag, "/R3 cnt ack"}, 64'(a), 64'd1);
        for (int k = 0; k < n; k++) begin
            send(wbuf[k], a);
            chk({tag, " data ack"}, 64'(a), 64'(k < NREG));
            if (k < NREG) model[k] = wbuf[k];
        end
        i2c_stop();
    endtask

    task automatic rd_block(input int n, input string tag);
        logic a;
        logic [7:0] b;
        i2c_start();
        send(8'hD5, a);                chk({tag, "/R2 rd addr ack"}, 64'(a), 64'd1);
        recv(n > 0, b);                chk({tag, "/R5 count"}, 64'(b), 64'd7);
        for (int k = 0; k < n; k++) begin
            recv(k < n - 1, b);
            chk({tag, "/R5 reg data"}, 64'(b), 64'(model[k]));
        end
        i2c_stop();
    endtask

    task automatic fill_rand(input int n);
        for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] b;
        void'($urandom(32'd4242));
        for (int i = 0; i < NREG; i++) model[i] = dflt(i);
        repeat (6) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1 reset state
        chk("R1 defaults", 64'(ctrl_o), 64'(pack_model()));
        chk("R1 released", 64'(sda_oe), 64'd0);
        rd_block(NREG, "R1 readback");

        // R3 full write, R5 read back
        fill_rand(NREG);
        wr_block(NREG, "R3");
        chk("R3 bus", 64'(ctrl_o), 64'(pack_model()));
        rd_block(NREG, "R5");

        // R4 partial write
        fill_rand(3);
        wr_block(3, "R4");
        chk("R4 bus", 64'(ctrl_o), 64'(pack_model()));

        // R7 overflow bytes
        fill_rand(9);
        wr_block(9, "R7");
        chk("R7 bus", 64'(ctrl_o), 64'(pack_model()));

        // R8 foreign address
        i2c_start();
        send(8'hA0, a);  chk("R8 addr nack", 64'(a), 64'd0);
        send(8'h00, a);  chk("R8 ignored byte", 64'(a), 64'd0);
        i2c_stop();
        chk("R8 bus", 64'(ctrl_o), 64'(pack_model()));

        // R6 early NACK then released
        i2c_start();
        send(8'hD5, a);  chk("R6 addr ack", 64'(a), 64'd1);
        recv(1'b1, b);   chk("R6 count", 64'(b), 64'd7);
        recv(1'b0, b);   chk("R6 reg0", 64'(b), 64'(model[0]));
        recv(1'b0, b);   chk("R6 released", 64'(b), 64'hFF);
        i2c_stop();

        // R9 repeated start
        i2c_start();
        send(8'hD4, a);  chk("R9 wr addr", 64'(a), 64'd1);
        send(8'h11, a);
        send(8'h22, a);
        wbuf[0] = 8'h5C;
        send(wbuf[0], a); chk("R9 data ack", 64'(a), 64'd1);
        model[0] = wbuf[0];
        i2c_start();
        send(8'hD5, a);  chk("R9 rd addr after rs", 64'(a), 64'd1);
        recv(1'b1, b);   chk("R9 count", 64'(b), 64'd7);
        recv(1'b0, b);   chk("R9 reg0", 64'(b), 64'(model[0]));
        i2c_stop();
        chk("R9 bus", 64'(ctrl_o), 64'(pack_model()));

        // random lengths around the boundary
        for (int it = 0; it < 6; it++) begin
            int n;
            n = int'($urandom_range(9, 1));
            fill_rand(n);
            wr_block(n, "R4 rand");
            chk("R4 rand bus", 64'(ctrl_o), 64'(pack_model()));
            rd_block(NREG, "R5 rand");
        end

        chk("R10 oe moved while scl high", 64'(oe_viol), 64'd0);
        chk("R10 idle after stop", 64'(sda_oe), 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule